// File: doc/BRIEF.md
# Windowed Command and Status Port

This block is the host-facing control port of a network adapter. The host writes one 16-bit command word into it and reads one 16-bit status word back from the same place. Each command word holds a 5-bit opcode in its upper bits and an 11-bit argument in its lower bits. The commands select which bank of registers appears at the lower offsets, turn the receive and transmit paths on and off, reset those paths or the whole adapter, raise interrupts by software, acknowledge interrupts and load an interrupt mask.

The status word reports four things: the current register window in its top three bits, a busy flag while a reset command is still running, the seven latched interrupt causes, and an interrupt latch in bit 0. Other units of the adapter raise causes through single-cycle event pins. The block drives plain level enables and single-cycle reset strobes to the receive and transmit units, and one interrupt line, which is high when any enabled cause is set.

Top module: `cmdstat_port`

## Requirements
- R1: The command word splits into opcode = bits 15..11 and argument = bits 10..0. Opcode 1 loads argument bits 2..0 as the window number, and argument bits 10..3 have no effect. The new window shows on `window_o` and on status bits 15..13 from the cycle after the write.
- R2: After reset, the status word is 0x0000, the window is 0, both path enables are 0, all strobes are 0 and `irq_o` is 0.
- R3: Opcode 4 sets `rx_en_o`. Opcode 3 clears it. Opcode 5 clears it and pulses `rx_rst_o` high for exactly the one cycle after the write.
- R4: Opcode 9 sets `tx_en_o`. Opcode 10 clears it. Opcode 11 clears it and pulses `tx_rst_o` high for exactly the one cycle after the write.
- R5: Opcode 0 does all of the following: it pulses `glob_rst_o` for one cycle, sets the window to 0, clears both enables, clears status bits 7..0 and clears the mask. The clearing wins over any event that arrives in the same cycle.
- R6: After an accepted opcode 0, 5 or 11, status bit 12 reads 1 for exactly BUSY_CYCLES cycles, starting the cycle after the write, and then reads 0. Any command written while bit 12 reads 1 has no effect.
- R7: A high `evt_i[n]` (n = 1..7) in a cycle sets status bit n from the next cycle. Whenever any cause bit 1..7 is set in a cycle, status bit 0 (the latch) is set as well.
- R8: Opcode 12 sets status bit 6 (interrupt requested) and the latch bit 0.
- R9: Opcode 13 clears each status bit n (n = 0..7) whose argument bit n is 1. A cause event on the same bit in the same cycle wins, and that bit stays set.
- R10: Opcode 14 loads argument bits 7..1 as the enable for cause bits 7..1. `irq_o` is 1 exactly when some status bit n in 1..7 is set and its mask bit n is 1.
- R11: Opcodes 2, 6, 7, 8 and 15..31 change no output and no status bit, and do not set status bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode and argument |
| evt_i | input | 7 | Cause events for status bits 7..1 (index 1..7) |
| status_o | output | 16 | Status word |
| window_o | output | 3 | Currently selected register window |
| rx_en_o | output | 1 | Receive path enable |
| tx_en_o | output | 1 | Transmit path enable |
| rx_rst_o | output | 1 | Receive reset strobe |
| tx_rst_o | output | 1 | Transmit reset strobe |
| glob_rst_o | output | 1 | Global reset strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Two operations can land on the same cause bit in one cycle: an acknowledge that clears the bit, and a cause event that sets it. The bench provokes this by writing opcode 13 with bit 3 set while `evt_i[3]` is high in the same cycle, and expects bit 3 and the latch to remain set. It repeats the case with a global reset against a simultaneous event, where the clearing must win. It also overlaps a window select with the busy period of an earlier reset, and expects the window to stay unchanged.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int CMD_W   = 16;
  localparam int OPC_W   = 5;
  localparam int ARG_W   = 11;
  localparam int WIN_W   = 3;
  localparam int CAUSE_W = 8;
  localparam int CAUSE_REQ = 6;

  typedef enum logic [OPC_W-1:0] {
    OP_GLOBAL_RST = 5'd0,
    OP_WIN_SEL    = 5'd1,
    OP_RX_OFF     = 5'd3,
    OP_RX_ON      = 5'd4,
    OP_RX_RST     = 5'd5,
    OP_TX_ON      = 5'd9,
    OP_TX_OFF     = 5'd10,
    OP_TX_RST     = 5'd11,
    OP_IRQ_REQ    = 5'd12,
    OP_IRQ_ACK    = 5'd13,
    OP_IRQ_MASK   = 5'd14
  } opcode_e;

  typedef struct packed {
    logic glob_rst;
    logic win_sel;
    logic rx_off;
    logic rx_on;
    logic rx_rst;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic irq_req;
    logic irq_ack;
    logic irq_mask;
  } cmd_vec_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdstat_pkg::*;
(
  input  logic             we_i,
  input  logic             busy_i,
  input  logic [CMD_W-1:0] word_i,
  output cmd_vec_t         cmd_o,
  output logic             known_o,
  output logic             starts_busy_o
);
  logic [OPC_W-1:0] opc;
  cmd_vec_t         raw;
  logic             accept;

  assign opc    = word_i[CMD_W-1 -: OPC_W];
  assign accept = we_i & ~busy_i;

  always_comb begin
    raw = '0;
    case (opc)
      OP_GLOBAL_RST: raw.glob_rst = 1'b1;
      OP_WIN_SEL:    raw.win_sel  = 1'b1;
      OP_RX_OFF:     raw.rx_off   = 1'b1;
      OP_RX_ON:      raw.rx_on    = 1'b1;
      OP_RX_RST:     raw.rx_rst   = 1'b1;
      OP_TX_ON:      raw.tx_on    = 1'b1;
      OP_TX_OFF:     raw.tx_off   = 1'b1;
      OP_TX_RST:     raw.tx_rst   = 1'b1;
      OP_IRQ_REQ:    raw.irq_req  = 1'b1;
      OP_IRQ_ACK:    raw.irq_ack  = 1'b1;
      OP_IRQ_MASK:   raw.irq_mask = 1'b1;
      default:       raw = '0;
    endcase
  end

  assign known_o       = |raw;
  assign cmd_o         = accept ? raw : '0;
  assign starts_busy_o = cmd_o.glob_rst | cmd_o.rx_rst | cmd_o.tx_rst;
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i | (cnt_q != '0);
    cnt_d  = start_i ? CNT_LOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o); // R6
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import cmdstat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all_i,
  input  logic               ack_i,
  input  logic               req_i,
  input  logic               mask_we_i,
  input  logic [CAUSE_W-1:0] arg_i,
  input  logic [CAUSE_W-1:1] evt_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [CAUSE_W-1:1] set_vec;
  logic [CAUSE_W-1:1] mask_q, mask_d;
  logic               cause_en, mask_en;

  for (genvar i = 1; i < CAUSE_W; i++) begin : g_cause
    if (i == CAUSE_REQ) begin : g_req
      assign set_vec[i] = evt_i[i] | req_i;
    end else begin : g_evt
      assign set_vec[i] = evt_i[i];
    end
    assign cause_d[i] = ~clr_all_i &
                        (set_vec[i] | (cause_q[i] & ~(ack_i & arg_i[i])));
  end

  assign cause_d[0] = ~clr_all_i &
                      ((|set_vec) | (cause_q[0] & ~(ack_i & arg_i[0])));

  always_comb begin
    cause_en = clr_all_i | ack_i | (|set_vec);
    mask_en  = clr_all_i | mask_we_i;
    mask_d   = clr_all_i ? '0 : arg_i[CAUSE_W-1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = |(cause_q[CAUSE_W-1:1] & mask_q);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !clr_all_i && set_vec == '0) |=> ((cause_q & $past(arg_i)) == '0)); // R9
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all_i && set_vec != '0) |=> cause_q[0]); // R7
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (cause_q == '0 && !irq_o)); // R5
endmodule

// File: rtl/path_ctrl.sv
module path_ctrl
  import cmdstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_vec_t         cmd_i,
  input  logic [WIN_W-1:0] win_arg_i,
  output logic [WIN_W-1:0] window_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             rx_rst_o,
  output logic             tx_rst_o,
  output logic             glob_rst_o
);
  logic [WIN_W-1:0] win_q, win_d;
  logic             rx_q, rx_d, tx_q, tx_d;
  logic             win_en, rx_en, tx_en;
  logic             rxs_q, txs_q, gs_q;

  always_comb begin
    win_en = cmd_i.glob_rst | cmd_i.win_sel;
    win_d  = cmd_i.glob_rst ? '0 : win_arg_i;
    rx_en  = cmd_i.glob_rst | cmd_i.rx_on | cmd_i.rx_off | cmd_i.rx_rst;
    rx_d   = cmd_i.rx_on & ~cmd_i.glob_rst;
    tx_en  = cmd_i.glob_rst | cmd_i.tx_on | cmd_i.tx_off | cmd_i.tx_rst;
    tx_d   = cmd_i.tx_on & ~cmd_i.glob_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
      rxs_q <= 1'b0;
      txs_q <= 1'b0;
      gs_q  <= 1'b0;
    end else begin
      if (win_en) win_q <= win_d;
      if (rx_en)  rx_q  <= rx_d;
      if (tx_en)  tx_q  <= tx_d;
      rxs_q <= cmd_i.rx_rst;
      txs_q <= cmd_i.tx_rst;
      gs_q  <= cmd_i.glob_rst;
    end
  end

  assign window_o   = win_q;
  assign rx_en_o    = rx_q;
  assign tx_en_o    = tx_q;
  assign rx_rst_o   = rxs_q;
  assign tx_rst_o   = txs_q;
  assign glob_rst_o = gs_q;

  AST_RX_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_o |-> !rx_en_o); // R3
  AST_TX_RST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_o |-> !tx_en_o); // R4
  AST_GRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    glob_rst_o |-> (window_o == '0 && !rx_en_o && !tx_en_o)); // R5
endmodule

// File: rtl/cmdstat_port.sv
module cmdstat_port
  import cmdstat_pkg::*;
#(
  parameter int BUSY_CYCLES = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_we,
  input  logic [15:0]  cmd_data,
  input  logic [7:1]   evt_i,
  output logic [15:0]  status_o,
  output logic [2:0]   window_o,
  output logic         rx_en_o,
  output logic         tx_en_o,
  output logic         rx_rst_o,
  output logic         tx_rst_o,
  output logic         glob_rst_o,
  output logic         irq_o
);
  cmd_vec_t           cmd;
  logic               busy, known, start_busy;
  logic [CAUSE_W-1:0] cause;

  cmd_decode u_dec (
    .we_i          (cmd_we),
    .busy_i        (busy),
    .word_i        (cmd_data),
    .cmd_o         (cmd),
    .known_o       (known),
    .starts_busy_o (start_busy)
  );

  busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_busy),
    .busy_o  (busy)
  );

  intr_ctrl u_intr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (cmd.glob_rst),
    .ack_i     (cmd.irq_ack),
    .req_i     (cmd.irq_req),
    .mask_we_i (cmd.irq_mask),
    .arg_i     (cmd_data[CAUSE_W-1:0]),
    .evt_i     (evt_i),
    .cause_o   (cause),
    .irq_o     (irq_o)
  );

  path_ctrl u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .win_arg_i  (cmd_data[WIN_W-1:0]),
    .window_o   (window_o),
    .rx_en_o    (rx_en_o),
    .tx_en_o    (tx_en_o),
    .rx_rst_o   (rx_rst_o),
    .tx_rst_o   (tx_rst_o),
    .glob_rst_o (glob_rst_o)
  );

  assign status_o = {window_o, busy, 4'b0000, cause};

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !known && !busy) |=> (!status_o[12] && $stable(window_o)
                                     && $stable(rx_en_o) && $stable(tx_en_o))); // R11
  AST_WIN_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(window_o)); // R6
  AST_ARG_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.win_sel && cmd_data[ARG_W-1:WIN_W] != '0) |=> (window_o == $past(cmd_data[WIN_W-1:0]))); // R1
endmodule

// File: tb/cmdstat_port_tb.sv
module cmdstat_port_tb;
  localparam int BUSY = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [15:0] cmd_data;
  logic [7:1]  evt_i;
  logic [15:0] status_o;
  logic [2:0]  window_o;
  logic        rx_en_o, tx_en_o, rx_rst_o, tx_rst_o, glob_rst_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_cause;
  logic [7:1] m_mask;
  logic [2:0] m_win;
  logic       m_rx, m_tx, m_rxs, m_txs, m_gs;
  int         m_cnt;

  always #4 clk = ~clk;

  cmdstat_port #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .evt_i(evt_i), .status_o(status_o), .window_o(window_o),
    .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_rst_o(rx_rst_o),
    .tx_rst_o(tx_rst_o), .glob_rst_o(glob_rst_o), .irq_o(irq_o)
  );

  function automatic logic [27:0] exp_vec();
    logic [15:0] st;
    st = {m_win, (m_cnt != 0), 4'b0000, m_cause};
    return {st, m_win, m_rx, m_tx, m_rxs, m_txs, m_gs, |(m_cause[7:1] & m_mask)};
  endfunction

  function automatic logic [27:0] act_vec();
    return {status_o, window_o, rx_en_o, tx_en_o, rx_rst_o, tx_rst_o, glob_rst_o, irq_o};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (act_vec() !== exp_vec()) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (status/win/rx/tx/rxs/txs/gs/irq)",
               tag, act_vec(), exp_vec());
    end
  endtask

  function automatic bit is_known(input logic [4:0] op);
    return (op == 0 || op == 1 || op == 3 || op == 4 || op == 5 || op == 9 ||
            op == 10 || op == 11 || op == 12 || op == 13 || op == 14);
  endfunction

  // called at a negedge; drives, advances one edge, updates model, compares
  task automatic step(input logic we, input logic [4:0] op, input logic [10:0] arg,
                      input logic [7:1] evt, input string tag);
    logic acc, g;
    logic [7:1] setv;
    logic [7:0] nc;
    cmd_we = we; cmd_data = {op, arg}; evt_i = evt;
    @(posedge clk); #1;
    acc = we && (m_cnt == 0) && is_known(op);
    g = acc && op == 0;
    setv = evt;
    if (acc && op == 12) setv[6] = 1'b1;
    nc = m_cause;
    if (acc && op == 13) nc = nc & ~arg[7:0];
    nc[7:1] = nc[7:1] | setv;
    if (setv != 0) nc[0] = 1'b1;
    if (g) nc = '0;
    m_cause = nc;
    if (g) m_mask = '0; else if (acc && op == 14) m_mask = arg[7:1];
    if (g) m_win = '0; else if (acc && op == 1) m_win = arg[2:0];
    if (g || (acc && (op == 3 || op == 5))) m_rx = 1'b0; else if (acc && op == 4) m_rx = 1'b1;
    if (g || (acc && (op == 10 || op == 11))) m_tx = 1'b0; else if (acc && op == 9) m_tx = 1'b1;
    m_rxs = acc && op == 5;
    m_txs = acc && op == 11;
    m_gs  = g;
    if (acc && (op == 0 || op == 5 || op == 11)) m_cnt = BUSY;
    else if (m_cnt > 0) m_cnt--;
    @(negedge clk);
    cmd_we = 1'b0; evt_i = '0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 5'd0, 11'd0, 7'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; cmd_data = '0; evt_i = '0;
    m_cause = '0; m_mask = '0; m_win = '0; m_rx = 0; m_tx = 0;
    m_rxs = 0; m_txs = 0; m_gs = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    compare("R2 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R2 after reset");

    // R1: every window, upper argument bits filled with junk
    for (int w = 0; w < 8; w++)
      step(1'b1, 5'd1, {8'(w * 37 + 5), 3'(w)}, 7'd0, "R1 window select");

    // R11: every unknown opcode with all argument bits set
    for (int op = 0; op < 32; op++)
      if (!is_known(5'(op))) step(1'b1, 5'(op), 11'h7FF, 7'd0, "R11 unknown opcode");

    // R3 / R4: enables and reset strobes
    step(1'b1, 5'd4, 11'd0, 7'd0, "R3 rx enable");
    step(1'b1, 5'd3, 11'd0, 7'd0, "R3 rx disable");
    step(1'b1, 5'd4, 11'd0, 7'd0, "R3 rx enable again");
    step(1'b1, 5'd5, 11'd0, 7'd0, "R3 rx reset strobe");
    idle(BUSY + 1, "R6 busy decay after rx reset");
    step(1'b1, 5'd9, 11'd0, 7'd0, "R4 tx enable");
    step(1'b1, 5'd10, 11'd0, 7'd0, "R4 tx disable");
    step(1'b1, 5'd9, 11'd0, 7'd0, "R4 tx enable again");
    step(1'b1, 5'd11, 11'd0, 7'd0, "R4 tx reset strobe");
    idle(BUSY + 1, "R6 busy decay after tx reset");

    // R7 / R9: each cause set by event, then cleared by ack
    for (int n = 1; n < 8; n++) begin
      step(1'b0, 5'd0, 11'd0, 7'(1 << (n - 1)), "R7 cause event");
      step(1'b1, 5'd13, 11'(1 << n), 7'd0, "R9 ack single cause");
    end
    step(1'b1, 5'd13, 11'h001, 7'd0, "R9 ack latch bit");

    // R8
    step(1'b1, 5'd12, 11'd0, 7'd0, "R8 software request");
    step(1'b1, 5'd13, 11'h0FF, 7'd0, "R9 ack all");

    // R10: mask bit n against event bit m
    for (int n = 1; n < 8; n++) begin
      step(1'b1, 5'd14, 11'(1 << n), 7'd0, "R10 load mask");
      for (int m = 1; m < 8; m++) begin
        step(1'b0, 5'd0, 11'd0, 7'(1 << (m - 1)), "R10 irq versus mask");
        step(1'b1, 5'd13, 11'h0FF, 7'd0, "R10 ack clears irq");
      end
    end
    step(1'b1, 5'd14, 11'h0FE, 7'd0, "R10 full mask");

    // R9 collision: ack and event on bit 3 in one cycle
    step(1'b0, 5'd0, 11'd0, 7'b0000100, "R7 set bit 3");
    step(1'b1, 5'd13, 11'h009, 7'b0000100, "R9 event wins over ack");
    step(1'b1, 5'd13, 11'h0FF, 7'd0, "R9 ack after collision");

    // R6 / R5: global reset with state set and simultaneous event
    step(1'b1, 5'd1, 11'd6, 7'd0, "R1 window 6");
    step(1'b1, 5'd4, 11'd0, 7'd0, "R3 rx on");
    step(1'b1, 5'd9, 11'd0, 7'd0, "R4 tx on");
    step(1'b0, 5'd0, 11'd0, 7'b1010101, "R7 multiple causes");
    step(1'b1, 5'd0, 11'd0, 7'b0000011, "R5 global reset beats event");
    step(1'b1, 5'd1, 11'd5, 7'd0, "R6 window select ignored while busy");
    step(1'b1, 5'd4, 11'd0, 7'd0, "R6 rx enable ignored while busy");
    step(1'b1, 5'd0, 11'd0, 7'd0, "R6 reset ignored while busy");
    idle(2, "R6 busy drops");
    step(1'b1, 5'd1, 11'd5, 7'd0, "R6 window accepted after busy");
    step(1'b1, 5'd14, 11'h0FE, 7'b1000000, "R10 mask and event together");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule